// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt request flags for 32 priority levels (0 lowest, 31 highest), filters them through per-level enables, a global enable and a programmable priority floor, and hands the single most urgent request to a processor core. The request appears as a level-sensitive `irq` together with a 16-bit vector word address of `0xFFC0 + 2*level`. Levels 30 and 31 are non-maskable. Level 31 is the reset class, and taking it first wipes all maskable state. Some levels are shared by several event sources. In the default build these are levels 18, 19, 24 and 30.

The core accepts a request by pulsing `irq_ack` and leaves a handler by pulsing `irq_ret`. While a handler runs at level L, only a request above L may preempt it. The interrupted level is saved on an internal level stack and restored on return. Software reaches the flags, the enables and the control word through a small write-only register port. That port has set and clear operations for the flags.

The sequencer has three states. `ST_IDLE` waits for an eligible request. `ST_WIPE` clears maskable state before a level-31 entry. `ST_PRESENT` drives `irq` and holds the vector. The transitions are as follows:
- *select* (`ST_IDLE`→`ST_PRESENT`) happens when an eligible level below 31 is found.
- *reset-select* (`ST_IDLE`→`ST_WIPE`) happens when level 31 wins.
- *wipe-done* (`ST_WIPE`→`ST_PRESENT`) always follows `ST_WIPE` after one cycle.
- *accept* (`ST_PRESENT`→`ST_IDLE`) happens on `irq_ack`.

Top module: `vpic_top`

## Requirements
- R1: A flag raised on `src_flag_set[p]` in cycle k makes `irq` rise after the second following clock edge. `irq_vector` then reads `0xFFC0 + 2*p`.
- R2: When several eligible flags are pending, the highest level is presented.
- R3: A maskable flag stays latched while its enable (register address 2, bit p) or the global enable (address 3, bit 0) is low. It is presented as soon as both are set.
- R4: A maskable level p is eligible only if p is strictly greater than the threshold in address 3, bits [5:1].
- R5: Levels 30 and 31 are presented regardless of the enables, the global enable and the threshold.
- R6: From the rise of `irq` until `irq_ack` is sampled, `irq` stays high and `irq_vector` stays unchanged.
- R7: Acknowledging a level clears its flag, except for the shared levels 18, 19, 24 and 30. Those flags stay set until software clears them.
- R8: Acknowledging a level below 30 clears the global enable. Acknowledging level 30 or 31 leaves it as it was.
- R9: While a handler is active at level L, only a level above L is presented. Acknowledging it saves L on the level stack, and `irq_ret` restores L.
- R10: A level-31 entry passes through `ST_WIPE` for one cycle before `irq` rises. `ST_WIPE` clears all maskable flags, all enables, the global enable, the threshold and the level stack.
- R11: Writing ones to address 0 sets those flags, and writing ones to address 1 clears them. A hardware set of a bit in the same cycle as a clear of that bit leaves the flag set.
- R12: When the level stack (8 entries) is full, no further preemption is presented until a return frees an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag_set | input | 32 | Hardware flag-set pulses, one bit per level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 flag set, 1 flag clear, 2 enables, 3 control {threshold[5:1], global enable[0]} |
| wr_data | input | 32 | Register write data |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core returns from the current handler |
| irq | output | 1 | Level-sensitive interrupt request |
| irq_vector | output | 16 | Vector word address of the presented level |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a hardware flag set and a software clear of the same bit. The bench provokes this by driving `src_flag_set` and a write to the clear address on one edge. It then judges the outcome by enabling the level and expecting the vector to appear.

The second pair is an acknowledge and a return, which can fall together with the stack at its limit. This is provoked by nesting nine levels deep. The bench then checks that a tenth, higher level stays hidden until one return, after which it is presented.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WIPE    = 2'd1,
        ST_PRESENT = 2'd2
    } seq_state_e;

    localparam logic [1:0] ADDR_FLAG_SET = 2'd0;
    localparam logic [1:0] ADDR_FLAG_CLR = 2'd1;
    localparam logic [1:0] ADDR_ENABLE   = 2'd2;
    localparam logic [1:0] ADDR_CONTROL  = 2'd3;

    // Word address of the vector slot for a level: base plus two bytes per level.
    function automatic logic [15:0] lvl_to_vec(input logic [15:0] base, input logic [15:0] lvl);
        return base + (lvl << 1);
    endfunction

endpackage

// File: rtl/vpic_flag_bank.sv
module vpic_flag_bank
    import vpic_pkg::*;
#(
    parameter int unsigned NL = 32,
    parameter int unsigned LW = 5,
    parameter logic [NL-1:0] NMI_LEVELS = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] hw_set,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [NL-1:0] wr_data,
    input  logic          wipe,
    input  logic [NL-1:0] ack_clr,
    input  logic          gie_clr,
    output logic [NL-1:0] flags,
    output logic [NL-1:0] en,
    output logic          gie,
    output logic [LW-1:0] thr
);

    logic [NL-1:0] sw_set;
    logic [NL-1:0] sw_clr;
    logic          ctrl_wr;
    logic          ctrl_unused;

    always_comb begin
        sw_set  = (wr_en && wr_addr == ADDR_FLAG_SET) ? wr_data : '0;
        sw_clr  = (wr_en && wr_addr == ADDR_FLAG_CLR) ? wr_data : '0;
        ctrl_wr = wr_en && (wr_addr == ADDR_CONTROL);
    end

    assign ctrl_unused = ^wr_data[NL-1:LW+1];

    // Hardware set is OR-ed in last so it dominates any clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (wipe) begin
            flags <= (flags & NMI_LEVELS & ~ack_clr) | hw_set;
        end else begin
            flags <= (flags & ~sw_clr & ~ack_clr) | sw_set | hw_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= '0;
            gie <= 1'b0;
            thr <= '0;
        end else if (wipe) begin
            en  <= '0;
            gie <= 1'b0;
            thr <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_ENABLE) begin
                en <= wr_data & ~NMI_LEVELS;
            end
            if (ctrl_wr) begin
                gie <= wr_data[0];
                thr <= wr_data[LW:1];
            end else if (gie_clr) begin
                gie <= 1'b0;
            end
        end
    end

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set))); // R11

    AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (((flags & ~NMI_LEVELS & ~$past(hw_set)) == '0) && (en == '0) && !gie && (thr == '0))); // R10

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
    parameter int unsigned NL = 32,
    parameter int unsigned LW = 5,
    parameter logic [NL-1:0] NMI_LEVELS = '0
) (
    input  logic [NL-1:0] flags,
    input  logic [NL-1:0] en,
    input  logic          gie,
    input  logic [LW-1:0] thr,
    input  logic          svc_active,
    input  logic [LW-1:0] svc_lvl,
    input  logic          stack_full,
    output logic          any,
    output logic [LW-1:0] sel
);

    logic [NL-1:0] elig;

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            logic mask_ok;
            logic nest_ok;
            mask_ok = NMI_LEVELS[i] || (gie && en[i] && (LW'(i) > thr));
            nest_ok = !svc_active || (!stack_full && (LW'(i) > svc_lvl));
            elig[i] = flags[i] && mask_ok && nest_ok;
        end
    end

    // Ascending scan: the last eligible level seen is the highest.
    always_comb begin
        any = |elig;
        sel = '0;
        for (int i = 0; i < NL; i++) begin
            if (elig[i]) begin
                sel = LW'(i);
            end
        end
    end

endmodule

// File: rtl/vpic_level_stack.sv
module vpic_level_stack #(
    parameter int unsigned LW    = 5,
    parameter int unsigned DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          enter,
    input  logic [LW-1:0] enter_lvl,
    input  logic          leave,
    output logic          active,
    output logic [LW-1:0] cur_lvl,
    output logic          full
);

    localparam int unsigned SPW = $clog2(DEPTH + 1);
    localparam int unsigned IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LW-1:0]  stk [DEPTH];
    logic [SPW-1:0] sp;
    logic [SPW-1:0] sp_m1;
    logic [IW-1:0]  push_idx;
    logic [IW-1:0]  pop_idx;

    always_comb begin
        sp_m1    = sp - 1'b1;
        push_idx = sp[IW-1:0];
        pop_idx  = sp_m1[IW-1:0];
        full     = active && (sp == SPW'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp      <= '0;
            active  <= 1'b0;
            cur_lvl <= '0;
        end else if (wipe) begin
            sp      <= '0;
            active  <= 1'b0;
            cur_lvl <= '0;
        end else if (enter && leave) begin
            // Return and new entry together: the saved context is unchanged.
            cur_lvl <= enter_lvl;
            active  <= 1'b1;
        end else if (enter) begin
            if (active) begin
                stk[push_idx] <= cur_lvl;
                sp            <= sp + 1'b1;
            end
            cur_lvl <= enter_lvl;
            active  <= 1'b1;
        end else if (leave && active) begin
            if (sp != '0) begin
                cur_lvl <= stk[pop_idx];
                sp      <= sp_m1;
            end else begin
                active <= 1'b0;
            end
        end
    end

    AST_NO_STACK_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && !leave && !wipe) |-> !full); // R12

    AST_LEAVE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (leave && !enter && !wipe && active && sp == '0) |=> !active); // R9

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int unsigned   NUM_LEVELS    = 32,
    parameter int unsigned   STACK_DEPTH   = 8,
    parameter logic [15:0]   VEC_BASE      = 16'hFFC0,
    parameter logic [31:0]   NMI_LEVELS    = 32'hC000_0000,
    parameter logic [31:0]   SHARED_LEVELS = 32'h410C_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] src_flag_set,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [NUM_LEVELS-1:0] wr_data,
    input  logic                  irq_ack,
    input  logic                  irq_ret,
    output logic                  irq,
    output logic [15:0]           irq_vector
);

    localparam int unsigned LW = $clog2(NUM_LEVELS);
    localparam logic [LW-1:0] WIPE_LVL = LW'(NUM_LEVELS - 1);
    localparam logic [NUM_LEVELS-1:0] NMI_MASK    = NMI_LEVELS[NUM_LEVELS-1:0];
    localparam logic [NUM_LEVELS-1:0] SHARED_MASK = SHARED_LEVELS[NUM_LEVELS-1:0];

    seq_state_e state, state_nx;
    logic [LW-1:0]         pres_lvl;
    logic [NUM_LEVELS-1:0] flags, en, ack_clr;
    logic                  gie, gie_clr, wipe, take;
    logic [LW-1:0]         thr, sel_lvl, svc_lvl;
    logic                  arb_any, svc_active, stack_full;

    vpic_flag_bank #(.NL(NUM_LEVELS), .LW(LW), .NMI_LEVELS(NMI_MASK)) u_flags (
        .clk(clk), .rst_n(rst_n), .hw_set(src_flag_set),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wipe(wipe), .ack_clr(ack_clr), .gie_clr(gie_clr),
        .flags(flags), .en(en), .gie(gie), .thr(thr)
    );

    vpic_arbiter #(.NL(NUM_LEVELS), .LW(LW), .NMI_LEVELS(NMI_MASK)) u_arb (
        .flags(flags), .en(en), .gie(gie), .thr(thr),
        .svc_active(svc_active), .svc_lvl(svc_lvl), .stack_full(stack_full),
        .any(arb_any), .sel(sel_lvl)
    );

    vpic_level_stack #(.LW(LW), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .wipe(wipe),
        .enter(take), .enter_lvl(pres_lvl), .leave(irq_ret),
        .active(svc_active), .cur_lvl(svc_lvl), .full(stack_full)
    );

    // Next-state decision.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (arb_any) begin
                    state_nx = (sel_lvl == WIPE_LVL) ? ST_WIPE : ST_PRESENT;
                end
            end
            ST_WIPE:    state_nx = ST_PRESENT;
            ST_PRESENT: begin
                if (irq_ack) begin
                    state_nx = ST_IDLE;
                end
            end
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register and latched level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pres_lvl <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && arb_any) begin
                pres_lvl <= sel_lvl;
            end
        end
    end

    // Outputs and side effects of the current state.
    always_comb begin
        irq        = (state == ST_PRESENT);
        irq_vector = lvl_to_vec(VEC_BASE, 16'(pres_lvl));
        wipe       = (state == ST_WIPE);
        take       = (state == ST_PRESENT) && irq_ack;
        ack_clr    = '0;
        if (take && !SHARED_MASK[pres_lvl]) begin
            ack_clr[pres_lvl] = 1'b1;
        end
        gie_clr    = take && !NMI_MASK[pres_lvl];
    end

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRESENT && !irq_ack) |=> (irq && $stable(irq_vector))); // R6

    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vector[0] == 1'b0 && irq_vector >= VEC_BASE)); // R1

    AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && arb_any && svc_active) |=> (pres_lvl > $past(svc_lvl))); // R9

    AST_WIPE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRESENT && pres_lvl == WIPE_LVL && $past(state) != ST_PRESENT)
            |-> ($past(state) == ST_WIPE)); // R10

endmodule

// File: tb/vpic_top_tb.sv
module vpic_top_tb;

    typedef struct packed {
        logic [31:0] raise;
        logic [31:0] en;
        logic        gie;
        logic [4:0]  thr;
        logic        exp_irq;
        logic [15:0] exp_vec;
    } row_t;

    localparam int NROWS = 9;
    localparam row_t ROWS [NROWS] = '{
        '{32'h0004_0000, 32'h0004_0000, 1'b1, 5'd0,  1'b1, 16'hFFE4}, // R1 level 18
        '{32'h0210_0000, 32'h0210_0000, 1'b1, 5'd0,  1'b1, 16'hFFF2}, // R2 20 vs 25
        '{32'h0020_0000, 32'h0020_0000, 1'b0, 5'd0,  1'b0, 16'h0000}, // R3 gie off
        '{32'h0020_0000, 32'h0000_0000, 1'b1, 5'd0,  1'b0, 16'h0000}, // R3 enable off
        '{32'h0020_0000, 32'h0020_0000, 1'b1, 5'd21, 1'b0, 16'h0000}, // R4 equal thr
        '{32'h0020_0000, 32'h0020_0000, 1'b1, 5'd20, 1'b1, 16'hFFEA}, // R4 above thr
        '{32'h4000_0000, 32'h0000_0000, 1'b0, 5'd29, 1'b1, 16'hFFFC}, // R5 nmi
        '{32'h4400_0000, 32'h0400_0000, 1'b1, 5'd0,  1'b1, 16'hFFFC}, // R2 26 vs 30
        '{32'h0108_0000, 32'h0008_0000, 1'b1, 5'd0,  1'b1, 16'hFFE6}  // R3 24 disabled
    };
    localparam string ROW_REQ [NROWS] = '{"R1", "R2", "R3", "R3", "R4", "R4", "R5", "R2", "R3"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_flag_set = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq;
    logic [15:0] irq_vector;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vpic_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_flag_set(src_flag_set),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq(irq), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; src_flag_set = '0; wr_en = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic raise(input logic [31:0] bits);
        @(negedge clk); src_flag_set = bits;
        @(negedge clk); src_flag_set = '0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic ret();
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        check("R1 reset", 32'(irq), 32'd0);

        // Table walk
        for (int r = 0; r < NROWS; r++) begin
            do_reset();
            reg_wr(2'd2, ROWS[r].en);
            reg_wr(2'd3, {26'd0, ROWS[r].thr, ROWS[r].gie});
            raise(ROWS[r].raise);
            @(negedge clk);
            check(ROW_REQ[r], 32'(irq), 32'(ROWS[r].exp_irq));
            if (ROWS[r].exp_irq) begin
                check(ROW_REQ[r], 32'(irq_vector), 32'(ROWS[r].exp_vec));
                ack();
            end
        end

        // R1 latency: low after one edge, high after two
        do_reset();
        reg_wr(2'd2, 32'h0004_0000);
        reg_wr(2'd3, 32'd1);
        raise(32'h0004_0000);
        check("R1 latency low", 32'(irq), 32'd0);
        @(negedge clk);
        check("R1 latency high", 32'(irq), 32'd1);
        // R6 held while not acknowledged
        raise(32'h0400_0000);
        reg_wr(2'd2, 32'h0404_0000);
        @(negedge clk);
        check("R6 vector held", 32'(irq_vector), 32'hFFE4);
        ack();

        // R3 latched then released
        do_reset();
        reg_wr(2'd2, 32'h0020_0000);
        raise(32'h0020_0000);
        @(negedge clk);
        check("R3 masked", 32'(irq), 32'd0);
        reg_wr(2'd3, 32'd1);
        @(negedge clk);
        check("R3 released", 32'(irq_vector), 32'hFFEA);

        // R7 / R8 / R11 acknowledge side effects
        do_reset();
        reg_wr(2'd2, 32'h0024_0000);
        reg_wr(2'd3, 32'd1);
        raise(32'h0020_0000);
        @(negedge clk);
        check("R7 present 21", 32'(irq_vector), 32'hFFEA);
        ack(); ret();
        raise(32'h0004_0000);
        @(negedge clk); @(negedge clk);
        check("R8 gie cleared", 32'(irq), 32'd0);
        reg_wr(2'd3, 32'd1);
        @(negedge clk);
        check("R7 single flag cleared", 32'(irq_vector), 32'hFFE4);
        ack(); ret();
        reg_wr(2'd3, 32'd1);
        @(negedge clk);
        check("R7 shared flag kept", 32'(irq), 32'd1);
        ack(); ret();
        reg_wr(2'd1, 32'h0004_0000);
        reg_wr(2'd3, 32'd1);
        @(negedge clk); @(negedge clk);
        check("R11 software clear", 32'(irq), 32'd0);

        // R8 level 30 keeps gie
        do_reset();
        reg_wr(2'd2, 32'h0004_0000);
        reg_wr(2'd3, 32'd1);
        raise(32'h4000_0000);
        @(negedge clk);
        ack(); reg_wr(2'd1, 32'h4000_0000); ret();
        raise(32'h0004_0000);
        @(negedge clk);
        check("R8 nmi keeps gie", 32'(irq_vector), 32'hFFE4);

        // R9 nesting and return
        do_reset();
        reg_wr(2'd2, 32'h0224_0000);
        reg_wr(2'd3, 32'd1);
        raise(32'h0020_0000);
        @(negedge clk);
        ack();
        reg_wr(2'd3, 32'd1);
        raise(32'h0004_0000);
        @(negedge clk); @(negedge clk);
        check("R9 lower blocked", 32'(irq), 32'd0);
        raise(32'h0200_0000);
        @(negedge clk);
        check("R9 higher preempts", 32'(irq_vector), 32'hFFF2);
        ack();
        reg_wr(2'd3, 32'd1);
        ret();
        @(negedge clk); @(negedge clk);
        check("R9 restored level blocks", 32'(irq), 32'd0);
        ret();
        @(negedge clk);
        check("R9 idle after pops", 32'(irq_vector), 32'hFFE4);

        // R10 reset-class entry wipes state
        do_reset();
        reg_wr(2'd2, 32'h0020_0000);
        reg_wr(2'd3, 32'd10);
        reg_wr(2'd0, 32'h0020_0000);
        raise(32'h8000_0000);
        @(negedge clk);
        check("R10 wipe cycle", 32'(irq), 32'd0);
        @(negedge clk);
        check("R10 reset vector", 32'(irq_vector), 32'hFFFE);
        ack(); ret();
        reg_wr(2'd3, 32'd1);
        reg_wr(2'd2, 32'h0020_0000);
        @(negedge clk); @(negedge clk);
        check("R10 flag wiped", 32'(irq), 32'd0);
        raise(32'h0020_0000);
        @(negedge clk);
        check("R10 threshold wiped", 32'(irq_vector), 32'hFFEA);

        // R11 hardware set beats same-cycle clear
        do_reset();
        reg_wr(2'd2, 32'h0020_0000);
        @(negedge clk);
        src_flag_set = 32'h0020_0000; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0020_0000;
        @(negedge clk);
        src_flag_set = '0; wr_en = 1'b0;
        reg_wr(2'd3, 32'd1);
        @(negedge clk);
        check("R11 hardware wins", 32'(irq_vector), 32'hFFEA);

        // R12 stack full blocks preemption
        do_reset();
        reg_wr(2'd2, 32'h0000_07FE);
        for (int l = 1; l <= 9; l++) begin
            reg_wr(2'd3, 32'd1);
            raise(32'd1 << l);
            @(negedge clk);
            check("R12 nest entry", 32'(irq_vector), 32'hFFC0 + 32'(2 * l));
            ack();
        end
        reg_wr(2'd3, 32'd1);
        raise(32'h0000_0400);
        @(negedge clk); @(negedge clk);
        check("R12 full blocks", 32'(irq), 32'd0);
        ret();
        @(negedge clk);
        check("R12 freed entry", 32'(irq_vector), 32'hFFD4);
        ack();

        summary();
        $finish;
    end

endmodule